// File: doc/BRIEF.md
# Global-History Branch Direction Predictor

This block guesses whether the next conditional branch will be taken, using only the outcomes of the branches that resolved most recently. A shift register of recent outcomes selects one entry in a table of 2-bit saturating counters. The high bit of the selected counter is the guess. The table is addressed by outcome history and not by branch address. Because of this, the block can learn branches whose outcome follows a repeating sequence, or that correlate with the branches just before them.

The front end raises a request and gets the guess one cycle later, together with the table index that produced it. The front end keeps that index with the branch. When the branch resolves, the front end returns the index and the real outcome on the update port. That trains the counter that was actually consulted, even if the history has moved on since the prediction. Every resolved branch also shifts its outcome into the history. Target addresses and any mixing with the branch address are handled elsewhere.

Top module: `ghist_dir_predictor`

## Requirements
- R1: After reset the outcome history is all zeros, every counter holds 2, and `predValid` is low. The first request therefore returns taken with index 0.
- R2: A request in cycle k gives `predValid` high in cycle k+1, and in no other case. `predIdx` then equals the history value at the sampling edge. `predTaken` is 1 exactly when the counter at that index is 2 or 3.
- R3: Each update shifts `updTaken` (1 = taken) into bit 0 of the history. Every other bit moves up one place and the top bit is lost.
- R4: An update with `updTaken`=1 adds one to the counter at `updIdx`, and the counter stays at 3 once it is there.
- R5: An update with `updTaken`=0 subtracts one from the counter at `updIdx`, and the counter stays at 0 once it is there.
- R6: An update changes no counter other than the one at `updIdx`, and without an update no counter changes.
- R7: When a request and an update share a clock edge, the prediction uses the history and counter values from before that update.
- R8: For a branch whose outcomes repeat taken, not-taken, not-taken, the predictions become correct after a few periods and stay correct.
- R9: The counter trained is the one named by `updIdx`, even when it differs from the current history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| predReq | input | 1 | Request a prediction for the next branch |
| updValid | input | 1 | A branch has resolved this cycle |
| updTaken | input | 1 | Actual outcome of the resolved branch, 1 = taken |
| updIdx | input | HIST_W | Table index that was returned with the prediction for this branch |
| predValid | output | 1 | Prediction outputs are valid this cycle |
| predTaken | output | 1 | Predicted direction, 1 = taken |
| predIdx | output | HIST_W | Table index (history value) that produced this prediction |

## Verification
A history register that shifts wrongly shows up at `predIdx` on the first request after the update that caused it. This is one cycle after the request. A counter that trains wrongly, or leaks into a neighbouring entry, stays hidden until the history next lands on that entry. So the bench forces the history onto every entry after saturating it up and down. It then checks the one-step hysteresis that separates a saturated counter from one that wrapped. A reference model runs beside the design through a long pseudo-random run and a period-three branch pattern. Any table or history divergence therefore surfaces on the first prediction that touches it.

// File: rtl/ghp_pkg.sv
package ghp_pkg;

  // counter width and its reset value (weakly taken)
  localparam int CNT_W = 2;
  localparam logic [CNT_W-1:0] CNT_INIT = 2'b10;
  localparam logic [CNT_W-1:0] CNT_MAX  = 2'b11;
  localparam logic [CNT_W-1:0] CNT_MIN  = 2'b00;

  // strobes from control to datapath
  typedef struct packed {
    logic predLatch;   // capture read result into output registers
    logic histShift;   // shift an outcome into the history
    logic cntWrite;    // train one counter
    logic cntUp;       // direction of training / bit shifted in
  } ghpStrobes_t;

  function automatic logic [CNT_W-1:0] satStep(input logic [CNT_W-1:0] cur,
                                               input logic up);
    logic [CNT_W-1:0] nxt;
    if (up) nxt = (cur == CNT_MAX) ? cur : cur + 1'b1;
    else    nxt = (cur == CNT_MIN) ? cur : cur - 1'b1;
    return nxt;
  endfunction

endpackage

// File: rtl/ghp_sat_cell.sv
module ghp_sat_cell
  import ghp_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             up,
  output logic [CNT_W-1:0] cnt
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     cnt <= CNT_INIT;
    else if (wrEn) cnt <= satStep(cnt, up);
  end

  // R4
  sat_top_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && up && cnt == CNT_MAX) |=> cnt == CNT_MAX);

  // R4
  inc_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && up && cnt != CNT_MAX) |=> cnt == CNT_W'($past(cnt) + 1'b1));

  // R5
  sat_floor_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !up && cnt == CNT_MIN) |=> cnt == CNT_MIN);

  // R5
  dec_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !up && cnt != CNT_MIN) |=> cnt == CNT_W'($past(cnt) - 1'b1));

endmodule

// File: rtl/ghp_ctrl.sv
module ghp_ctrl
  import ghp_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        predReq,
  input  logic        updValid,
  input  logic        updTaken,
  output ghpStrobes_t strb,
  output logic        predValid
);

  always_comb begin
    strb.predLatch = predReq;
    strb.histShift = updValid;
    strb.cntWrite  = updValid;
    strb.cntUp     = updTaken;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) predValid <= 1'b0;
    else       predValid <= predReq;
  end

endmodule

// File: rtl/ghp_datapath.sv
module ghp_datapath
  import ghp_pkg::*;
#(
  parameter int HIST_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ghpStrobes_t       strb,
  input  logic [HIST_W-1:0] updIdx,
  output logic              predTaken,
  output logic [HIST_W-1:0] predIdx
);

  localparam int NUM_ENT = 1 << HIST_W;

  logic [HIST_W-1:0]        ghr;
  logic [HIST_W:0]          ghrWide;
  logic [NUM_ENT*CNT_W-1:0] cntFlat;
  logic [CNT_W-1:0]         rdCnt;

  // history: newest outcome enters at bit 0
  assign ghrWide = {ghr, strb.cntUp};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               ghr <= '0;
    else if (strb.histShift) ghr <= ghrWide[HIST_W-1:0];
  end

  // counter table
  for (genvar i = 0; i < NUM_ENT; i++) begin : g_ent
    logic hit;
    assign hit = strb.cntWrite && (updIdx == HIST_W'(i));
    ghp_sat_cell u_cell (
      .clk  (clk),
      .rstN (rstN),
      .wrEn (hit),
      .up   (strb.cntUp),
      .cnt  (cntFlat[i*CNT_W +: CNT_W])
    );
  end

  // read with pre-update values
  assign rdCnt = cntFlat[ghr*CNT_W +: CNT_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      predTaken <= 1'b0;
      predIdx   <= '0;
    end else if (strb.predLatch) begin
      predTaken <= rdCnt[CNT_W-1];
      predIdx   <= ghr;
    end
  end

  // R3
  hist_in_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.histShift |=> ghr[0] == $past(strb.cntUp));

  // R3
  hist_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.histShift |=> $stable(ghr));

  // R6
  table_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.cntWrite |=> $stable(cntFlat));

endmodule

// File: rtl/ghist_dir_predictor.sv
module ghist_dir_predictor
  import ghp_pkg::*;
#(
  parameter int HIST_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              predReq,
  input  logic              updValid,
  input  logic              updTaken,
  input  logic [HIST_W-1:0] updIdx,
  output logic              predValid,
  output logic              predTaken,
  output logic [HIST_W-1:0] predIdx
);

  ghpStrobes_t strb;

  ghp_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .predReq   (predReq),
    .updValid  (updValid),
    .updTaken  (updTaken),
    .strb      (strb),
    .predValid (predValid)
  );

  ghp_datapath #(.HIST_W(HIST_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .updIdx    (updIdx),
    .predTaken (predTaken),
    .predIdx   (predIdx)
  );

  // R2
  valid_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    predReq |=> predValid);

  // R2
  valid_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !predReq |=> !predValid);

endmodule

// File: tb/tb_ghist_dir_predictor.sv
module tb_ghist_dir_predictor;

  localparam int HW  = 4;
  localparam int ENT = 1 << HW;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          predReq = 1'b0;
  logic          updValid = 1'b0;
  logic          updTaken = 1'b0;
  logic [HW-1:0] updIdx = '0;
  logic          predValid;
  logic          predTaken;
  logic [HW-1:0] predIdx;

  int vecCnt = 0;
  int errCnt = 0;
  int cycles = 0;

  // reference model
  int            mCnt [ENT];
  logic [HW-1:0] mGhr;

  ghist_dir_predictor #(.HIST_W(HW)) dut (
    .clk       (clk),
    .rstN      (rstN),
    .predReq   (predReq),
    .updValid  (updValid),
    .updTaken  (updTaken),
    .updIdx    (updIdx),
    .predValid (predValid),
    .predTaken (predTaken),
    .predIdx   (predIdx)
  );

  always #4 clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    vecCnt++;
    if (act != exp) begin
      errCnt++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; predReq = 0; updValid = 0; updTaken = 0; updIdx = '0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
    for (int i = 0; i < ENT; i++) mCnt[i] = 2;
    mGhr = '0;
    check("R1 predValid after reset", int'(predValid), 0);
  endtask

  // one cycle: drive at negedge, model the edge, compare at next negedge
  task automatic step(input string tag, input logic pr, input logic uv,
                      input logic ut, input logic [HW-1:0] ui);
    int            expT;
    logic [HW-1:0] expI;
    predReq = pr; updValid = uv; updTaken = ut; updIdx = ui;
    expT = (mCnt[mGhr] >= 2) ? 1 : 0;
    expI = mGhr;
    if (uv) begin
      if (ut) mCnt[ui] = (mCnt[ui] == 3) ? 3 : mCnt[ui] + 1;
      else    mCnt[ui] = (mCnt[ui] == 0) ? 0 : mCnt[ui] - 1;
      mGhr = {mGhr[HW-2:0], ut};
    end
    @(negedge clk);
    check({tag, " predValid"}, int'(predValid), int'(pr));
    if (pr) begin
      check({tag, " predTaken"}, int'(predTaken), expT);
      check({tag, " predIdx"}, int'(predIdx), int'(expI));
    end
    predReq = 0; updValid = 0;
  endtask

  // steer history to a target with updates on a scratch entry
  task automatic setGhr(input logic [HW-1:0] tgt, input logic [HW-1:0] scratch);
    for (int b = HW - 1; b >= 0; b--) step("R3 steer", 1'b0, 1'b1, tgt[b], scratch);
  endtask

  initial begin
    while (cycles < 200000) begin
      @(posedge clk);
      cycles++;
    end
    errCnt++;
    $display("FAIL watchdog actual=%0d expected<%0d", cycles, 200000);
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    logic        gotT;
    logic [HW-1:0] gotI;

    // R1: reset state, first prediction taken at index 0
    doReset();
    step("R1 first predict", 1'b1, 1'b0, 1'b0, '0);
    check("R1 first taken", int'(predTaken), 1);
    check("R1 first idx", int'(predIdx), 0);

    // R4/R5: saturate every entry both ways, probe hysteresis
    for (int e = 0; e < ENT; e++) begin
      logic [HW-1:0] ei = HW'(e);
      logic [HW-1:0] sc = ei ^ HW'(ENT / 2);
      for (int k = 0; k < 5; k++) step("R4 train up", 1'b0, 1'b1, 1'b1, ei);
      step("R4 one down", 1'b0, 1'b1, 1'b0, ei);
      setGhr(ei, sc);
      step("R4 saturated high", 1'b1, 1'b0, 1'b0, '0);
      for (int k = 0; k < 6; k++) step("R5 train down", 1'b0, 1'b1, 1'b0, ei);
      step("R5 one up", 1'b0, 1'b1, 1'b1, ei);
      setGhr(ei, sc);
      step("R5 saturated low", 1'b1, 1'b0, 1'b0, '0);
    end

    // R7: same-edge predict and update uses old state
    doReset();
    step("R7 same edge", 1'b1, 1'b1, 1'b0, '0);
    check("R7 old counter", int'(predTaken), 1);
    check("R7 old history", int'(predIdx), 0);
    step("R7 after", 1'b1, 1'b0, 1'b0, '0);
    check("R7 trained counter", int'(predTaken), 0);

    // R9: train an entry other than the current history
    doReset();
    step("R9 remote train", 1'b0, 1'b1, 1'b0, HW'(5));
    step("R9 history unmoved", 1'b1, 1'b0, 1'b0, '0);
    check("R9 entry0 untouched", int'(predTaken), 1);
    setGhr(HW'(5), HW'(12));
    step("R9 probe", 1'b1, 1'b0, 1'b0, '0);
    check("R9 entry5 trained", int'(predTaken), 0);
    check("R3 idx after shifts", int'(predIdx), 5);

    // R8: period-three pattern T,NT,NT
    doReset();
    for (int b = 0; b < 60; b++) begin
      logic act = (b % 3 == 0);
      step("R8 predict", 1'b1, 1'b0, 1'b0, '0);
      gotT = predTaken;
      gotI = predIdx;
      if (b >= 24) check("R8 learned", int'(gotT), int'(act));
      step("R8 resolve", 1'b0, 1'b1, act, gotI);
    end

    // R2/R3/R6/R9: pseudo-random traffic against the model
    doReset();
    lfsr = 16'hACE1;
    for (int n = 0; n < 3000; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step("R6 random", lfsr[0], lfsr[1] | lfsr[2], lfsr[3] ^ lfsr[7],
           lfsr[11:8]);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
    $finish;
  end

endmodule